// File: doc/BRIEF.md
# Dual-Channel Disk I/O Address Router

This block sits between a host I/O port and the register targets of a two-channel disk controller. Every access carries an address, a byte size and a read/write strobe. The block compares the address against five programmable windows: a command block and a control block for each channel, and one bus-master register window shared by both channels. It then raises exactly one target select and passes that target the offset of the access within its window. For reads it returns the target's data, or zero when no target may answer.

The shared bus-master window is split by offset. Its lower half belongs to channel 0 and its upper half to channel 1, with the upper offsets rebased to start at zero. The block also watches command-block writes to keep a per-channel record of which of the two devices is addressed. When that device is not fitted, the block stops the access: a read returns zero and a write goes nowhere. The base addresses are loaded through a small programming port that ignores a value of zero.

The response to an access arrives in the cycle after the request. Selects, offset, write flag, error flag and device selection are registered. The returned read data is formed in that response cycle from the target's read bus.

Top module: `io_window_router`

## Requirements
- R1: An access whose size is not 1, 2 or 4 bytes gives a response with `rsp_err` = 1 and no target select. The size check is made even when I/O is disabled.
- R2: While `io_enable` = 0, a legal-size access gives a response with `rsp_err` = 0, no target select and read data 0. It does not change `dev_sel`.
- R3: When windows overlap, the first match in this order wins: channel 0 command (select bit 0), channel 0 control (bit 1), channel 1 command (bit 2), channel 1 control (bit 3), bus-master window. `tgt_hit` is never more than one-hot.
- R4: A window matches when base ≤ address < base + size. The address base + size − 1 matches and base + size does not.
- R5: `tgt_off` is the address minus the matched window's base. `tgt_wr` follows the access direction.
- R6: In the bus-master window, offsets below BM_BLK select channel 0 (bit 4) with the offset unchanged. Higher offsets select channel 1 (bit 5) with BM_BLK subtracted.
- R7: While `bm_enable` = 0, writes to the bus-master window are dropped with no select and no error. Reads of that window still go through.
- R8: A write to command-block offset 6 sets `dev_sel[ch]` to bit 4 of `acc_wdata`. The new selection applies to that same access.
- R9: If the device selected on a channel is absent (`dev_present[2*ch+dev_sel[ch]]` = 0), command and control reads return 0 and writes raise no select. No error is flagged.
- R10: A base write (`bar_wr`, index 0 = ch0 cmd, 1 = ch0 ctl, 2 = ch1 cmd, 3 = ch1 ctl, 4 = bus-master) takes effect only when `bar_value` is nonzero.
- R11: A legal-size access with I/O enabled that matches no window gives `rsp_err` = 1 and no select.
- R12: Every accepted request gives `rsp_valid` exactly one cycle later. In that cycle `rsp_rdata` equals `tgt_rdata` for a forwarded read, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Request strobe, one cycle per access |
| acc_addr | input | AW | Access address |
| acc_size | input | 3 | Access size in bytes |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wdata | input | 8 | Low byte of write data (device-select snoop) |
| io_enable | input | 1 | I/O decode enable |
| bm_enable | input | 1 | Bus-master write enable |
| dev_present | input | 4 | Device fitted, bit 2*ch+dev |
| bar_wr | input | 1 | Base programming strobe |
| bar_idx | input | 3 | Base register index |
| bar_value | input | AW | Base value |
| tgt_rdata | input | 32 | Read data from the selected target |
| rsp_valid | output | 1 | Response strobe |
| rsp_err | output | 1 | Illegal size or unmatched address |
| tgt_hit | output | 6 | One-hot target select |
| tgt_off | output | OFFW | Offset inside the target |
| tgt_wr | output | 1 | Forwarded access is a write |
| dev_sel | output | 2 | Selected device per channel |
| rsp_rdata | output | 32 | Returned read data |

## Verification
Each request is driven on a falling edge and is registered on the next rising edge. Every registered result, including the updated `dev_sel`, is therefore due on the falling edge one full cycle after the request. `rsp_rdata` is combinational from `tgt_rdata`, which the bench holds constant, so it is valid in that same response cycle. The driver queues the expected response as it drives, and the monitor pops one entry on each falling edge where `rsp_valid` is high. A response with no queued entry, or an entry left in the queue at the end, is reported as a failure. Base programming takes one edge, so the bench issues accesses only after that edge.

// File: rtl/io_rt_pkg.sv
package io_rt_pkg;
    localparam int NWIN = 5;
    localparam int NTGT = 6;
    localparam int W_CMD0 = 0;
    localparam int W_CTL0 = 1;
    localparam int W_CMD1 = 2;
    localparam int W_CTL1 = 3;
    localparam int W_BM   = 4;
    localparam int T_BM0  = 4;
    localparam int T_BM1  = 5;
    localparam int SEL_OFFSET = 6;
    localparam int SEL_BIT    = 4;
endpackage

// File: rtl/io_rt_bars.sv
module io_rt_bars
    import io_rt_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr,
    input  logic [2:0]               idx,
    input  logic [AW-1:0]            value,
    output logic [NWIN-1:0][AW-1:0]  base
);
    logic [NWIN-1:0][AW-1:0] base_d, base_q;

    always_comb begin
        base_d = base_q;
        if (wr && value != '0 && int'(idx) < NWIN)
            base_d[idx] = value;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) base_q <= '0;
        else        base_q <= base_d;
    end

    assign base = base_q;

    // R10: zero value never changes any base
    p_zero_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && value == '0) |=> $stable(base_q));
endmodule

// File: rtl/io_rt_window.sv
module io_rt_window #(
    parameter int AW   = 16,
    parameter int SIZE = 8,
    parameter int OFFW = 4
) (
    input  logic [AW-1:0]   base,
    input  logic [AW-1:0]   addr,
    output logic            hit,
    output logic [OFFW-1:0] off
);
    logic [AW:0]   limit;
    logic [AW-1:0] diff;

    always_comb begin
        limit = {1'b0, base} + (AW+1)'(SIZE);
        diff  = addr - base;
        hit   = (addr >= base) && ({1'b0, addr} < limit);
        off   = diff[OFFW-1:0];
    end
endmodule

// File: rtl/io_window_router.sv
module io_window_router
    import io_rt_pkg::*;
#(
    parameter int AW       = 16,
    parameter int CMD_SIZE = 8,
    parameter int CTL_SIZE = 4,
    parameter int BM_BLK   = 8,
    localparam int BM_SIZE = 2 * BM_BLK,
    localparam int MAXW    = (BM_SIZE > CMD_SIZE)
                             ? ((BM_SIZE > CTL_SIZE) ? BM_SIZE : CTL_SIZE)
                             : ((CMD_SIZE > CTL_SIZE) ? CMD_SIZE : CTL_SIZE),
    localparam int OFFW    = $clog2(MAXW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [AW-1:0]     acc_addr,
    input  logic [2:0]        acc_size,
    input  logic              acc_write,
    input  logic [7:0]        acc_wdata,
    input  logic              io_enable,
    input  logic              bm_enable,
    input  logic [3:0]        dev_present,
    input  logic              bar_wr,
    input  logic [2:0]        bar_idx,
    input  logic [AW-1:0]     bar_value,
    input  logic [31:0]       tgt_rdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [NTGT-1:0]   tgt_hit,
    output logic [OFFW-1:0]   tgt_off,
    output logic              tgt_wr,
    output logic [1:0]        dev_sel,
    output logic [31:0]       rsp_rdata
);
    localparam int WIN_SIZE [NWIN] = '{CMD_SIZE, CTL_SIZE, CMD_SIZE, CTL_SIZE, BM_SIZE};

    typedef struct packed {
        logic            valid;
        logic            err;
        logic [NTGT-1:0] hit;
        logic [OFFW-1:0] off;
        logic            wr;
        logic            blank;
        logic [1:0]      sel;
    } rsp_t;

    logic [NWIN-1:0][AW-1:0]   base;
    logic [NWIN-1:0]           win_hit;
    logic [NWIN-1:0][OFFW-1:0] win_off;
    rsp_t                      st_d, st_q;

    io_rt_bars #(.AW(AW)) u_bars (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (bar_wr),
        .idx   (bar_idx),
        .value (bar_value),
        .base  (base)
    );

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        io_rt_window #(.AW(AW), .SIZE(WIN_SIZE[g]), .OFFW(OFFW)) u_win (
            .base (base[g]),
            .addr (acc_addr),
            .hit  (win_hit[g]),
            .off  (win_off[g])
        );
    end

    logic            size_ok;
    logic            any_hit;
    logic [2:0]      win_idx;
    logic            ch;
    logic            sel_now;
    logic [OFFW-1:0] off_now;

    always_comb begin
        size_ok = (acc_size == 3'd1) || (acc_size == 3'd2) || (acc_size == 3'd4);
        any_hit = 1'b0;
        win_idx = '0;
        for (int i = NWIN - 1; i >= 0; i--) begin
            if (win_hit[i]) begin
                any_hit = 1'b1;
                win_idx = 3'(i);
            end
        end
        off_now = win_off[win_idx];
        ch      = win_idx[1];
        sel_now = st_q.sel[ch];

        st_d       = st_q;
        st_d.valid = acc_valid;
        st_d.err   = 1'b0;
        st_d.hit   = '0;
        st_d.off   = '0;
        st_d.wr    = 1'b0;
        st_d.blank = 1'b1;

        if (acc_valid) begin
            if (!size_ok) begin
                st_d.err = 1'b1;
            end else if (io_enable) begin
                if (!any_hit) begin
                    st_d.err = 1'b1;
                end else if (int'(win_idx) == W_BM) begin
                    if (!(acc_write && !bm_enable)) begin
                        st_d.wr    = acc_write;
                        st_d.blank = acc_write;
                        if (int'(off_now) < BM_BLK) begin
                            st_d.hit[T_BM0] = 1'b1;
                            st_d.off        = off_now;
                        end else begin
                            st_d.hit[T_BM1] = 1'b1;
                            st_d.off        = off_now - OFFW'(BM_BLK);
                        end
                    end
                end else begin
                    if (acc_write && !win_idx[0] && int'(off_now) == SEL_OFFSET)
                        sel_now = acc_wdata[SEL_BIT];
                    st_d.sel[ch] = sel_now;
                    if (dev_present[{ch, sel_now}]) begin
                        st_d.hit[win_idx] = 1'b1;
                        st_d.off          = off_now;
                        st_d.wr           = acc_write;
                        st_d.blank        = acc_write;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{default: '0, blank: 1'b1};
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.valid;
    assign rsp_err   = st_q.err;
    assign tgt_hit   = st_q.hit;
    assign tgt_off   = st_q.off;
    assign tgt_wr    = st_q.wr;
    assign dev_sel   = st_q.sel;
    assign rsp_rdata = st_q.blank ? 32'd0 : tgt_rdata;

    // R3: never more than one target
    p_hit_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tgt_hit));
    // R1: illegal size gives an error and no target
    p_size_err_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_size != 3'd1 && acc_size != 3'd2 && acc_size != 3'd4)
        |=> (rsp_err && tgt_hit == '0));
    // R2: disabled I/O routes nowhere and keeps the selection
    p_io_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !io_enable) |=> (tgt_hit == '0 && $stable(dev_sel)));
    // R7: bus-master writes dropped while disabled
    p_bm_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && !bm_enable)
        |=> !(tgt_wr && (tgt_hit[T_BM0] || tgt_hit[T_BM1])));
    // R8: selection changes only on an access
    p_sel_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> $stable(dev_sel));
    // R6: bus-master offsets stay inside one channel block
    p_bm_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_hit[T_BM0] || tgt_hit[T_BM1]) |-> (int'(tgt_off) < BM_BLK));
    // R12: a response follows every request
    p_rsp_timing_r12: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> rsp_valid);
endmodule

// File: tb/io_window_router_bench.sv
module io_window_router_bench;
    localparam int AW = 16;
    localparam int OFFW = 4;
    localparam logic [31:0] RD = 32'hCAFE_0123;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_valid = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic [2:0] acc_size = 3'd1;
    logic acc_write = 1'b0;
    logic [7:0] acc_wdata = '0;
    logic io_enable = 1'b0;
    logic bm_enable = 1'b0;
    logic [3:0] dev_present = 4'b0101;
    logic bar_wr = 1'b0;
    logic [2:0] bar_idx = '0;
    logic [AW-1:0] bar_value = '0;
    logic [31:0] tgt_rdata = RD;
    logic rsp_valid, rsp_err, tgt_wr;
    logic [5:0] tgt_hit;
    logic [OFFW-1:0] tgt_off;
    logic [1:0] dev_sel;
    logic [31:0] rsp_rdata;

    always #2 clk = ~clk;

    io_window_router #(.AW(AW)) u_io_window_router (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_size(acc_size), .acc_write(acc_write), .acc_wdata(acc_wdata),
        .io_enable(io_enable), .bm_enable(bm_enable), .dev_present(dev_present),
        .bar_wr(bar_wr), .bar_idx(bar_idx), .bar_value(bar_value),
        .tgt_rdata(tgt_rdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .tgt_hit(tgt_hit), .tgt_off(tgt_off), .tgt_wr(tgt_wr),
        .dev_sel(dev_sel), .rsp_rdata(rsp_rdata)
    );

    typedef struct {
        logic err; logic [5:0] hit; logic [OFFW-1:0] off; logic wr;
        logic [1:0] sel; logic [31:0] rdata; string tag;
    } exp_t;

    exp_t q[$];
    int total = 0;
    int bad = 0;
    logic [1:0] exp_sel = 2'b00;

    task automatic check(input string tag, input bit ok, input string act, input string exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%s expected=%s", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (q.size() == 0) begin
                check("R12", 1'b0, "unexpected response", "none");
            end else begin
                exp_t e;
                bit ok;
                e = q.pop_front();
                ok = (rsp_err == e.err) && (tgt_hit == e.hit) && (tgt_off == e.off) &&
                     (tgt_wr == e.wr) && (dev_sel == e.sel) && (rsp_rdata == e.rdata);
                check(e.tag, ok,
                    $sformatf("err=%0b hit=%b off=%0d wr=%0b sel=%b rd=%h",
                              rsp_err, tgt_hit, tgt_off, tgt_wr, dev_sel, rsp_rdata),
                    $sformatf("err=%0b hit=%b off=%0d wr=%0b sel=%b rd=%h",
                              e.err, e.hit, e.off, e.wr, e.sel, e.rdata));
            end
        end
    end

    task automatic access(input string tag, input logic [AW-1:0] a, input logic [2:0] sz,
                          input logic w, input logic [7:0] wd, input logic e_err,
                          input logic [5:0] e_hit, input int e_off, input logic [31:0] e_rd);
        exp_t e;
        e.err = e_err; e.hit = e_hit; e.off = OFFW'(e_off);
        e.wr = w && (e_hit != '0); e.sel = exp_sel; e.rdata = e_rd; e.tag = tag;
        q.push_back(e);
        acc_valid = 1'b1; acc_addr = a; acc_size = sz; acc_write = w; acc_wdata = wd;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic set_base(input int idx, input logic [AW-1:0] v);
        bar_wr = 1'b1; bar_idx = 3'(idx); bar_value = v;
        @(negedge clk);
        bar_wr = 1'b0;
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                check("reset", rsp_valid == 0 && dev_sel == 0 && tgt_hit == 0 && rsp_rdata == 0,
                      $sformatf("v=%0b sel=%b hit=%b", rsp_valid, dev_sel, tgt_hit), "v=0 sel=00 hit=0");

                // R2: I/O disabled
                access("R2 read off", 16'h0002, 3'd1, 1'b0, 8'h00, 0, 6'b0, 0, 0);
                access("R2 select write ignored", 16'h0006, 3'd1, 1'b1, 8'h10, 0, 6'b0, 0, 0);
                // R1: size error even with I/O disabled
                access("R1 size 3 io off", 16'h0002, 3'd3, 1'b0, 8'h00, 1, 6'b0, 0, 0);

                set_base(0, 16'h01F0);
                set_base(1, 16'h03F4);
                set_base(2, 16'h0170);
                set_base(3, 16'h0374);
                set_base(4, 16'hC000);
                io_enable = 1'b1;

                access("R5 cmd0 offset", 16'h01F2, 3'd2, 1'b0, 8'h00, 0, 6'b000001, 2, RD);
                access("R4 last byte", 16'h01F7, 3'd1, 1'b0, 8'h00, 0, 6'b000001, 7, RD);
                access("R4 R11 past end", 16'h01F8, 3'd1, 1'b0, 8'h00, 1, 6'b0, 0, 0);
                access("R3 ctl0", 16'h03F6, 3'd1, 1'b0, 8'h00, 0, 6'b000010, 2, RD);
                access("R3 cmd1", 16'h0171, 3'd4, 1'b0, 8'h00, 0, 6'b000100, 1, RD);
                access("R3 ctl1", 16'h0377, 3'd1, 1'b0, 8'h00, 0, 6'b001000, 3, RD);
                access("R11 below ctl1", 16'h0373, 3'd1, 1'b0, 8'h00, 1, 6'b0, 0, 0);
                access("R5 write", 16'h0172, 3'd2, 1'b1, 8'h55, 0, 6'b000100, 2, 0);

                // R3 overlap priority
                set_base(1, 16'h01F4);
                access("R3 overlap cmd0 wins", 16'h01F5, 3'd1, 1'b0, 8'h00, 0, 6'b000001, 5, RD);
                set_base(1, 16'h03F4);

                // R10 zero base ignored
                set_base(2, 16'h0000);
                access("R10 zero ignored", 16'h0171, 3'd1, 1'b0, 8'h00, 0, 6'b000100, 1, RD);

                // R1 sizes
                access("R1 size 0", 16'h01F0, 3'd0, 1'b0, 8'h00, 1, 6'b0, 0, 0);
                access("R1 size 3", 16'h01F0, 3'd3, 1'b1, 8'h00, 1, 6'b0, 0, 0);

                // R6 bus-master split
                access("R6 bm ch0", 16'hC003, 3'd1, 1'b0, 8'h00, 0, 6'b010000, 3, RD);
                access("R6 bm ch1", 16'hC00A, 3'd2, 1'b0, 8'h00, 0, 6'b100000, 2, RD);
                access("R6 bm ch1 top", 16'hC00F, 3'd1, 1'b0, 8'h00, 0, 6'b100000, 7, RD);
                access("R6 R11 bm end", 16'hC010, 3'd1, 1'b0, 8'h00, 1, 6'b0, 0, 0);

                // R7 bus-master write gate
                access("R7 write dropped", 16'hC002, 3'd1, 1'b1, 8'h01, 0, 6'b0, 0, 0);
                access("R7 read proceeds", 16'hC002, 3'd1, 1'b0, 8'h00, 0, 6'b010000, 2, RD);
                bm_enable = 1'b1;
                access("R7 write allowed", 16'hC00C, 3'd4, 1'b1, 8'h01, 0, 6'b100000, 4, 0);

                // R8 R9 device selection on channel 0, device 1 absent
                exp_sel = 2'b01;
                access("R8 R9 select absent dev", 16'h01F6, 3'd1, 1'b1, 8'h10, 0, 6'b0, 0, 0);
                access("R9 read absent cmd", 16'h01F0, 3'd1, 1'b0, 8'h00, 0, 6'b0, 0, 0);
                access("R9 read absent ctl", 16'h03F6, 3'd1, 1'b0, 8'h00, 0, 6'b0, 0, 0);
                access("R9 write absent", 16'h01F1, 3'd1, 1'b1, 8'hAA, 0, 6'b0, 0, 0);
                access("R8 other offset no change", 16'h01F5, 3'd1, 1'b1, 8'h00, 0, 6'b0, 0, 0);
                exp_sel = 2'b00;
                access("R8 deselect", 16'h01F6, 3'd1, 1'b1, 8'hE0, 0, 6'b000001, 6, 0);
                access("R8 read after deselect", 16'h01F0, 3'd1, 1'b0, 8'h00, 0, 6'b000001, 0, RD);

                // R8 channel 1, device 1 present
                dev_present = 4'b1101;
                exp_sel = 2'b10;
                access("R8 ch1 select dev1", 16'h0176, 3'd1, 1'b1, 8'h10, 0, 6'b000100, 6, 0);
                access("R8 ch1 ctl read", 16'h0375, 3'd1, 1'b0, 8'h00, 0, 6'b001000, 1, RD);
                access("R8 ctl offset 2 no snoop", 16'h0376, 3'd1, 1'b1, 8'h00, 0, 6'b001000, 2, 0);

                @(negedge clk);
                @(negedge clk);
                check("R12 drained", q.size() == 0, $sformatf("%0d", q.size()), "0");
            end
            begin
                repeat (5000) @(negedge clk);
                check("watchdog", 1'b0, "timeout", "finish");
            end
        join_any
        disable fork;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule